// File: doc/BRIEF.md
# Bunch Clock Phase Aligner

This block turns a machine clock into a bunch-rate strobe. A divider counts machine-clock cycles modulo a fixed ratio and raises a one-cycle enable each time its count returns to zero. The divider is not free-running with an arbitrary phase. A fast command carries a phase value and loads it into the divider with a constant, known latency, so the bunch clock can be placed exactly to one machine-clock period. This fits a command channel whose delivery latency is fixed.

A train-start marker opens a bunch train. It sets an in-train flag and zeroes a bunch counter, which then advances on every bunch-clock enable. A train-end command closes the train. The counter then freezes, and the divider keeps its phase through the inter-train gap, so the next train stays aligned without a new phase load. All logic runs in the machine-clock domain. The reset input asserts asynchronously and is released synchronously inside the block.

Top module: `bunch_phase_align`

## Requirements
- R1: While `rst_n` is low, `bc_en`, `in_train` and `bunch_cnt` are all zero. After `rst_n` rises, `bc_en` stays low through the first rising clock edge. It is high in the cycle that follows the second rising edge.
- R2: With no phase load, `bc_en` is a single-cycle pulse that repeats every `RATIO` clock cycles.
- R3: A command with `cmd_valid` high, `cmd_op` = 4'h1 and `cmd_arg` = v < `RATIO` is sampled at edge E. `bc_en` is then high in the cycle after edge E + ((`RATIO` − v) mod `RATIO`), and every `RATIO` cycles after that.
- R4: A phase command whose `cmd_arg` is `RATIO` or more is ignored, and the divider phase continues undisturbed.
- R5: A sampled `train_start` sets `in_train` to 1 and `bunch_cnt` to 0 at that edge. It wins over a train-end command sampled at the same edge.
- R6: While `in_train` is 1, `bunch_cnt` increments at every edge where `bc_en` is high, and holds at every other edge.
- R7: `bunch_cnt` saturates at 2^`CNT_W` − 1 rather than wrapping.
- R8: A command with `cmd_op` = 4'h2 (train end) clears `in_train` at the sampling edge. `bunch_cnt` then holds its value until the next train start.
- R9: Train start and train end leave the divider phase unchanged. The bunch-clock schedule runs through trains and gaps alike.
- R10: Commands with any other `cmd_op` value, and any inputs on `cmd_op`/`cmd_arg` while `cmd_valid` is low, change neither the phase nor the train state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, released synchronously inside |
| cmd_valid | input | 1 | Fast-command strobe |
| cmd_op | input | 4 | Command opcode: 4'h1 phase load, 4'h2 train end |
| cmd_arg | input | ARG_W | Phase value for a phase load |
| train_start | input | 1 | Train-start marker |
| bc_en | output | 1 | Bunch-clock enable, one cycle per bunch period |
| bunch_cnt | output | CNT_W | Bunches seen in the current train |
| in_train | output | 1 | High between train start and train end |

## Verification
The bench builds two instances side by side on the same stimulus. One uses the defaults (`RATIO` 16, `CNT_W` 8). The other uses `RATIO` 5 with `CNT_W` 3. The second instance exercises a divider wrap that is not a power of two and phase values that the 4-bit argument can carry but the divider cannot hold (R4). It also makes counter saturation reachable within a few dozen cycles (R7). Sharing the stimulus means a single command lands at different phases in the two dividers, which checks the fixed load latency at two ratios at once.

// File: rtl/bpa_pkg.sv
package bpa_pkg;
  localparam int BPA_OP_W = 4;

  typedef enum logic [BPA_OP_W-1:0] {
    BPA_OP_NOP   = 4'h0,
    BPA_OP_PHASE = 4'h1,
    BPA_OP_TEND  = 4'h2
  } bpa_op_e;
endpackage

// File: rtl/bpa_rst_sync.sv
module bpa_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/bpa_cmd_decode.sv
module bpa_cmd_decode
  import bpa_pkg::*;
#(
  parameter int RATIO = 16,
  parameter int ARG_W = 4,
  parameter int PH_W  = 4
) (
  input  logic                cmd_valid,
  input  logic [BPA_OP_W-1:0] cmd_op,
  input  logic [ARG_W-1:0]    cmd_arg,
  output logic                ph_load,
  output logic [PH_W-1:0]     ph_val,
  output logic                train_end
);
  logic [31:0] arg_ext;
  logic        is_phase;

  always_comb begin
    arg_ext   = 32'(cmd_arg);
    is_phase  = cmd_valid && (cmd_op == BPA_OP_PHASE);
    // out-of-range phase values are dropped, not folded
    ph_load   = is_phase && (arg_ext < 32'(RATIO));
    ph_val    = arg_ext[PH_W-1:0];
    train_end = cmd_valid && (cmd_op == BPA_OP_TEND);
  end
endmodule

// File: rtl/bpa_divider.sv
module bpa_divider #(
  parameter int RATIO = 16,
  parameter int PH_W  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ph_load,
  input  logic [PH_W-1:0] ph_val,
  output logic            bc_en
);
  localparam logic [PH_W-1:0] PH_MAX = PH_W'(RATIO - 1);

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] ph_d;

  always_comb begin
    if (ph_load)             ph_d = ph_val;
    else if (ph_q == PH_MAX) ph_d = '0;
    else                     ph_d = ph_q + PH_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign bc_en = rst_n && (ph_q == '0);
endmodule

// File: rtl/bpa_train.sv
module bpa_train #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             train_start,
  input  logic             train_end,
  input  logic             bc_en,
  output logic             in_train,
  output logic [CNT_W-1:0] bunch_cnt
);
  logic             tr_q, tr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    if (train_start)    tr_d = 1'b1;
    else if (train_end) tr_d = 1'b0;
    else                tr_d = tr_q;

    cnt_en = train_start || (tr_q && bc_en && (cnt_q != '1));
    cnt_d  = train_start ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tr_q <= 1'b0;
    else        tr_q <= tr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign in_train  = tr_q;
  assign bunch_cnt = cnt_q;
endmodule

// File: rtl/bunch_phase_align.sv
module bunch_phase_align
  import bpa_pkg::*;
#(
  parameter int RATIO = 16,
  parameter int CNT_W = 8,
  parameter int ARG_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [BPA_OP_W-1:0] cmd_op,
  input  logic [ARG_W-1:0]    cmd_arg,
  input  logic                train_start,
  output logic                bc_en,
  output logic [CNT_W-1:0]    bunch_cnt,
  output logic                in_train
);
  localparam int PH_W = $clog2(RATIO);

  generate
    if (RATIO < 2) begin : g_bad_ratio
      $error("RATIO must be at least 2");
    end
  endgenerate

  logic             rst_sync_n;
  logic             ph_load;
  logic [PH_W-1:0]  ph_val;
  logic             train_end;

  bpa_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bpa_cmd_decode #(.RATIO(RATIO), .ARG_W(ARG_W), .PH_W(PH_W)) u_dec (
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_arg   (cmd_arg),
    .ph_load   (ph_load),
    .ph_val    (ph_val),
    .train_end (train_end)
  );

  bpa_divider #(.RATIO(RATIO), .PH_W(PH_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ph_load (ph_load),
    .ph_val  (ph_val),
    .bc_en   (bc_en)
  );

  bpa_train #(.CNT_W(CNT_W)) u_train (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .train_start (train_start),
    .train_end   (train_end),
    .bc_en       (bc_en),
    .in_train    (in_train),
    .bunch_cnt   (bunch_cnt)
  );
endmodule

// File: rtl/bunch_phase_align_chk.sv
module bunch_phase_align_chk #(
  parameter int CNT_W = 8,
  parameter int ARG_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             live,
  input logic             cmd_valid,
  input logic [3:0]       cmd_op,
  input logic [ARG_W-1:0] cmd_arg,
  input logic             train_start,
  input logic             bc_en,
  input logic [CNT_W-1:0] bunch_cnt,
  input logic             in_train
);
  logic load_zero;
  logic tend;
  assign load_zero = cmd_valid && (cmd_op == 4'h1) && (cmd_arg == '0);
  assign tend      = cmd_valid && (cmd_op == 4'h2);

  always @(negedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!bc_en && !in_train && (bunch_cnt == '0)); // R1
    end
  end

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!live)
    bc_en && !load_zero |=> !bc_en); // R2

  AST_LOAD_ZERO_FIRES: assert property (@(posedge clk) disable iff (!live)
    load_zero |=> bc_en); // R3

  AST_TRAIN_OPEN: assert property (@(posedge clk) disable iff (!live)
    train_start |=> (in_train && (bunch_cnt == '0))); // R5

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!live)
    in_train && !bc_en && !train_start |=> $stable(bunch_cnt)); // R6

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!live)
    (&bunch_cnt) && !train_start |=> (&bunch_cnt)); // R7

  AST_TRAIN_CLOSE: assert property (@(posedge clk) disable iff (!live)
    tend && !train_start |=> !in_train); // R8

  AST_GAP_FROZEN: assert property (@(posedge clk) disable iff (!live)
    !in_train && !train_start |=> $stable(bunch_cnt)); // R8
endmodule

bind bunch_phase_align bunch_phase_align_chk #(.CNT_W(CNT_W), .ARG_W(ARG_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .live        (rst_sync_n),
  .cmd_valid   (cmd_valid),
  .cmd_op      (cmd_op),
  .cmd_arg     (cmd_arg),
  .train_start (train_start),
  .bc_en       (bc_en),
  .bunch_cnt   (bunch_cnt),
  .in_train    (in_train)
);

// File: tb/bunch_phase_align_tb.sv
module bpa_scoreboard #(
  parameter int RATIO = 16,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [3:0]       cmd_op,
  input logic [3:0]       cmd_arg,
  input logic             train_start,
  input logic             bc_en,
  input logic [CNT_W-1:0] bunch_cnt,
  input logic             in_train
);
  localparam int MAXC = (1 << CNT_W) - 1;
  int n_chk;
  int n_bad;
  bit s1, s2, tr, bc;
  int ph, cnt;

  // expected behaviour per the requirements, updated at each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 = 0; s2 = 0; ph = 0; cnt = 0; tr = 0;
    end else if (!s2) begin
      s2 = s1; s1 = 1;
    end else begin
      bc = (ph == 0);
      if (train_start) cnt = 0;
      else if (tr && bc && cnt < MAXC) cnt = cnt + 1;
      if (train_start) tr = 1;
      else if (cmd_valid && cmd_op == 4'h2) tr = 0;
      if (cmd_valid && cmd_op == 4'h1 && int'(cmd_arg) < RATIO) ph = int'(cmd_arg);
      else ph = (ph + 1) % RATIO;
    end
  end

  always @(negedge clk) begin
    n_chk = n_chk + 3;
    if (bc_en !== (s2 && ph == 0)) begin
      n_bad++;
      $display("FAIL R3 ratio %0d bc_en act %0b exp %0b", RATIO, bc_en, (s2 && ph == 0));
    end
    if (int'(bunch_cnt) != cnt) begin
      n_bad++;
      $display("FAIL R6 ratio %0d bunch_cnt act %0d exp %0d", RATIO, bunch_cnt, cnt);
    end
    if (in_train !== tr) begin
      n_bad++;
      $display("FAIL R5 ratio %0d in_train act %0b exp %0b", RATIO, in_train, tr);
    end
  end
endmodule

module bunch_phase_align_tb;
  localparam int CLK_PERIOD = 20;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid;
  logic [3:0] cmd_op;
  logic [3:0] cmd_arg;
  logic       train_start;

  logic       bc_a, bc_b;
  logic [7:0] cnt_a;
  logic [2:0] cnt_b;
  logic       tr_a, tr_b;

  int n_own = 0;
  int bad_own = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bunch_phase_align u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_arg(cmd_arg), .train_start(train_start),
    .bc_en(bc_a), .bunch_cnt(cnt_a), .in_train(tr_a)
  );

  bunch_phase_align #(.RATIO(5), .CNT_W(3)) u_dut_r5 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_arg(cmd_arg), .train_start(train_start),
    .bc_en(bc_b), .bunch_cnt(cnt_b), .in_train(tr_b)
  );

  bpa_scoreboard #(.RATIO(16), .CNT_W(8)) u_sb_a (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_arg(cmd_arg), .train_start(train_start),
    .bc_en(bc_a), .bunch_cnt(cnt_a), .in_train(tr_a)
  );

  bpa_scoreboard #(.RATIO(5), .CNT_W(3)) u_sb_b (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_arg(cmd_arg), .train_start(train_start),
    .bc_en(bc_b), .bunch_cnt(cnt_b), .in_train(tr_b)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_own++;
    if (!ok) begin
      bad_own++;
      $display("FAIL %s act %0d exp %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic idle();
    cmd_valid = 1'b0; cmd_op = 4'h0; cmd_arg = 4'h0; train_start = 1'b0;
  endtask

  task automatic cmd(input logic [3:0] op, input logic [3:0] arg);
    cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg;
    cyc(1);
    idle();
  endtask

  task automatic first_pulse(output int pa, output int pb);
    pa = -1; pb = -1;
    for (int j = 0; j < 40; j++) begin
      if (pa < 0 && bc_a) pa = j;
      if (pb < 0 && bc_b) pb = j;
      cyc(1);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; idle();
    cyc(3);
    check(!bc_a && !bc_b, "R1 bc_en in reset", int'(bc_a | bc_b), 0);
    check(cnt_a == 0 && cnt_b == 0, "R1 bunch_cnt in reset", int'(cnt_a) + int'(cnt_b), 0);
    check(!tr_a && !tr_b, "R1 in_train in reset", int'(tr_a | tr_b), 0);
    rst_n = 1'b1;
    cyc(1);
    check(!bc_a, "R1 bc_en after first edge", int'(bc_a), 0);
    cyc(1);
    check(bc_a && bc_b, "R1 bc_en after second edge", int'(bc_a & bc_b), 1);
  endtask

  task automatic t_divide();
    int na = 0, nb = 0;
    for (int j = 0; j < 80; j++) begin
      if (bc_a) na++;
      if (bc_b) nb++;
      cyc(1);
    end
    check(na == 5, "R2 pulses in 80 cycles ratio 16", na, 5);
    check(nb == 16, "R2 pulses in 80 cycles ratio 5", nb, 16);
  endtask

  task automatic t_phase();
    int pa, pb;
    cmd(4'h1, 4'd0); first_pulse(pa, pb);
    check(pa == 0, "R3 load 0 ratio 16", pa, 0);
    check(pb == 0, "R3 load 0 ratio 5", pb, 0);
    cmd(4'h1, 4'd3); first_pulse(pa, pb);
    check(pa == 13, "R3 load 3 ratio 16", pa, 13);
    check(pb == 2, "R3 load 3 ratio 5", pb, 2);
    cmd(4'h1, 4'd15); first_pulse(pa, pb);
    check(pa == 1, "R3 load 15 ratio 16", pa, 1);
  endtask

  task automatic t_ignore();
    int pa, pb;
    cmd(4'h1, 4'd0);
    cmd(4'h1, 4'd9); first_pulse(pa, pb);
    check(pb == 4, "R4 arg 9 ignored ratio 5", pb, 4);
    check(pa == 7, "R3 arg 9 taken ratio 16", pa, 7);
    cmd(4'h1, 4'd0);
    cmd(4'h7, 4'd0); first_pulse(pa, pb);
    check(pa == 15, "R10 unknown opcode ratio 16", pa, 15);
    check(pb == 4, "R10 unknown opcode ratio 5", pb, 4);
    cmd(4'h1, 4'd0);
    cmd_valid = 1'b0; cmd_op = 4'h1; cmd_arg = 4'd0;
    cyc(1); idle();
    first_pulse(pa, pb);
    check(pa == 15, "R10 strobe low ignored", pa, 15);
  endtask

  task automatic t_train();
    int pa, pb;
    logic [7:0] held;
    cmd(4'h1, 4'd0);
    train_start = 1'b1; cyc(1); idle();
    check(tr_a && tr_b, "R5 in_train set", int'(tr_a & tr_b), 1);
    check(cnt_a == 0 && cnt_b == 0, "R5 count cleared", int'(cnt_a) + int'(cnt_b), 0);
    first_pulse(pa, pb);
    check(pa == 15, "R9 train start keeps phase", pa, 15);
    cyc(10);
    check(cnt_b == 3'd7, "R7 saturation ratio 5", int'(cnt_b), 7);
    check(cnt_a == 8'd3, "R6 bunch count ratio 16", int'(cnt_a), 3);
    cmd(4'h7, 4'd0);
    check(tr_a && tr_b, "R10 unknown opcode keeps train", int'(tr_a & tr_b), 1);
    cmd(4'h2, 4'd0);
    check(!tr_a && !tr_b, "R8 train end clears flag", int'(tr_a | tr_b), 0);
    held = cnt_a;
    cyc(40);
    check(cnt_a == held, "R8 count frozen in gap", int'(cnt_a), int'(held));
    cmd(4'h1, 4'd0);
    cmd(4'h2, 4'd0); first_pulse(pa, pb);
    check(pa == 15, "R9 train end keeps phase", pa, 15);
    check(pb == 4, "R9 train end keeps phase ratio 5", pb, 4);
    train_start = 1'b1; cmd_valid = 1'b1; cmd_op = 4'h2;
    cyc(1); idle();
    check(tr_a && cnt_a == 0, "R5 start wins over end", int'(tr_a), 1);
    cmd(4'h2, 4'd0);
    cyc(5);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==",
             n_own + u_sb_a.n_chk + u_sb_b.n_chk,
             bad_own + u_sb_a.n_bad + u_sb_b.n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad_own++;
    n_own++;
    $display("FAIL watchdog expired act 0 exp 1");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    idle();
    t_reset();
    t_divide();
    t_phase();
    t_ignore();
    t_train();
    report();
    $finish;
  end
endmodule